// File: doc/BRIEF.md
# Skewed Row Feeder for a Systolic Transform Array

This block sits in front of a four-column systolic array that computes small two-dimensional integer transforms by separable row and column passes. External memory writes one complete row of four samples in a single parallel transfer. The feeder queues those rows and hands each one to the array as a diagonal wavefront: lane 0 reaches column 0 first, and every later lane reaches its column one cycle behind its left neighbour. This matches the array's pipelined dataflow.

A second input accepts transposed intermediate rows returned after the first pass. These rows always win arbitration over fresh rows, so a block finishes its second pass before new data displaces it. Loading and issuing run concurrently. When nothing is stored, an empty slot enters the wavefront with zero data. Columns that are already working on earlier rows continue, and only the columns the bubble reaches go idle. A global issue enable lets the array hold back new rows without disturbing rows that are already in flight.

Top module: `line_skew_feeder`

## Requirements
- R1: While reset is asserted and directly after it, every column output is zero, col_valid and col_pass2 are all 0, empty is 1, full is 0, and ld_ready and fb_ready are 1.
- R2: A row is packed with lane k in bits [k*16 +: 16]. Suppose a row enters an idle feeder on a clock edge while issue_en is high. On the next edge, lane 0 appears on column 0 with col_valid[0]=1. Fresh rows leave in the order they were written.
- R3: Lane k of a row appears on column k exactly k cycles after lane 0 of the same row appears on column 0, with col_valid[k]=1.
- R4: In any cycle where column k carries no row, col_valid[k]=0 and its 16-bit data is zero.
- R5: A stored feedback row is issued before any stored fresh row and is marked with col_pass2=1 on each column it passes. Fresh rows carry col_pass2=0.
- R6: The fresh queue holds 8 rows, which is two 4x4 blocks. full=1 and ld_ready=0 exactly when 8 rows are held, and a write while full is dropped. The feedback queue holds 4 rows, fb_ready=0 when it is full, and a feedback write while full is dropped.
- R7: While issue_en is low, no new row enters column 0 and stored rows are kept. Rows already in the wavefront keep advancing through the later columns.
- R8: With issue_en high, a row can be written on every cycle and one row is issued per cycle, so consecutive rows occupy consecutive diagonals.
- R9: empty is 1 exactly when neither queue holds a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_en | input | 1 | Array allows a new row to enter column 0 |
| ld_valid | input | 1 | Fresh row write strobe |
| ld_row | input | 64 | Fresh row, four 16-bit lanes |
| ld_ready | output | 1 | Fresh queue can accept a row |
| fb_valid | input | 1 | Transposed feedback row write strobe |
| fb_row | input | 64 | Feedback row, four 16-bit lanes |
| fb_ready | output | 1 | Feedback queue can accept a row |
| col_data | output | 64 | Per-column sample, lane k in bits [k*16 +: 16] |
| col_valid | output | 4 | Column k holds a real sample |
| col_pass2 | output | 4 | Column k sample belongs to a feedback row |
| empty | output | 1 | Both queues hold no row |
| full | output | 1 | Fresh queue holds 8 rows |

## Verification
A row written on edge E reaches column 0 after edge E+1 and column k after edge E+1+k, as long as nothing of higher priority is waiting and issue_en is high. The flags change on the write or issue edge itself. The bench drives all inputs on the falling edge and samples one falling edge after each rising edge, so it can predict exactly which lane each column holds after every step. The stall, priority and capacity scenarios check the columns cycle by cycle along the diagonal, including the cycles where a column must read zero.

// File: rtl/line_skew_pkg.sv
package line_skew_pkg;

  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_FRESH    = 2'd1,
    SRC_FEEDBACK = 2'd2
  } src_e;

  // Second-pass rows win; fresh rows go only when no feedback row waits.
  function automatic src_e pick_source(input logic go, input logic fb_has,
                                       input logic fr_has);
    if (!go)         return SRC_NONE;
    else if (fb_has) return SRC_FEEDBACK;
    else if (fr_has) return SRC_FRESH;
    else             return SRC_NONE;
  endfunction

  // Cycles between column 0 and column k seeing the same row.
  function automatic int skew_of(input int k);
    return k;
  endfunction

endpackage

// File: rtl/row_fifo.sv
module row_fifo #(
  parameter int ROW_W = 64,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ROW_W-1:0] wr_row,
  input  logic             pop,
  output logic [ROW_W-1:0] rd_row,
  output logic             has_row,
  output logic             is_full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [ROW_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    count;
  logic             push_ok, pop_ok;

  assign is_full = (count == CW'(DEPTH));
  assign has_row = (count != '0);
  assign push_ok = push && !is_full;
  assign pop_ok  = pop && has_row;
  assign rd_row  = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wr_row;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6: a write presented while full must leave the write side untouched.
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && is_full) |=> $stable(wp));

  // R6: reading with nothing stored must not advance the read side.
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !has_row) |=> $stable(rp));

endmodule

// File: rtl/issue_arbiter.sv
module issue_arbiter
  import line_skew_pkg::*;
(
  input  logic go,
  input  logic fb_has,
  input  logic fr_has,
  output logic fb_pop,
  output logic fr_pop
);
  src_e src;

  always_comb begin
    src    = pick_source(go, fb_has, fr_has);
    fb_pop = (src == SRC_FEEDBACK);
    fr_pop = (src == SRC_FRESH);
  end

endmodule

// File: rtl/skew_line.sv
module skew_line
  import line_skew_pkg::*;
#(
  parameter int W     = 16,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_pass2,
  input  logic [LANES*W-1:0] in_row,
  output logic [LANES*W-1:0] col_data,
  output logic [LANES-1:0]   col_valid,
  output logic [LANES-1:0]   col_pass2
);
  logic [LANES-1:0] vchain, pchain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vchain <= '0;
      pchain <= '0;
    end else begin
      vchain <= {vchain[LANES-2:0], in_valid};
      pchain <= {pchain[LANES-2:0], in_valid & in_pass2};
    end
  end

  assign col_valid = vchain;
  assign col_pass2 = pchain;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int LEN = skew_of(k) + 1;
    logic [W-1:0] dchain [LEN];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int j = 0; j < LEN; j++) dchain[j] <= '0;
      end else begin
        dchain[0] <= in_valid ? in_row[k*W +: W] : '0;
        for (int j = 1; j < LEN; j++) dchain[j] <= dchain[j-1];
      end
    end

    assign col_data[k*W +: W] = dchain[LEN-1];

    // R4: an idle column slot carries zero data.
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !col_valid[k] |-> (col_data[k*W +: W] == '0));

    if (k > 0) begin : g_skew
      // R3: each column follows its left neighbour by exactly one cycle.
      assert_skew_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid[k-1] |=> (col_valid[k] && (col_pass2[k] == $past(col_pass2[k-1]))));
    end
  end

endmodule

// File: rtl/line_skew_feeder.sv
module line_skew_feeder
  import line_skew_pkg::*;
#(
  parameter int W     = 16,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue_en,
  input  logic               ld_valid,
  input  logic [LANES*W-1:0] ld_row,
  output logic               ld_ready,
  input  logic               fb_valid,
  input  logic [LANES*W-1:0] fb_row,
  output logic               fb_ready,
  output logic [LANES*W-1:0] col_data,
  output logic [LANES-1:0]   col_valid,
  output logic [LANES-1:0]   col_pass2,
  output logic               empty,
  output logic               full
);
  localparam int ROW_W    = LANES * W;
  localparam int FR_DEPTH = 2 * LANES;   // two blocks, ping-pong
  localparam int FB_DEPTH = LANES;       // one transposed block

  logic [ROW_W-1:0] fr_head, fb_head, sel_row;
  logic fr_has, fr_full, fb_has, fb_full;
  logic fr_pop, fb_pop, issue_valid;

  row_fifo #(.ROW_W(ROW_W), .DEPTH(FR_DEPTH)) u_fresh (
    .clk(clk), .rst_n(rst_n), .push(ld_valid), .wr_row(ld_row),
    .pop(fr_pop), .rd_row(fr_head), .has_row(fr_has), .is_full(fr_full));

  row_fifo #(.ROW_W(ROW_W), .DEPTH(FB_DEPTH)) u_feedback (
    .clk(clk), .rst_n(rst_n), .push(fb_valid), .wr_row(fb_row),
    .pop(fb_pop), .rd_row(fb_head), .has_row(fb_has), .is_full(fb_full));

  issue_arbiter u_arb (
    .go(issue_en), .fb_has(fb_has), .fr_has(fr_has),
    .fb_pop(fb_pop), .fr_pop(fr_pop));

  assign issue_valid = fb_pop | fr_pop;
  assign sel_row     = fb_pop ? fb_head : fr_head;

  skew_line #(.W(W), .LANES(LANES)) u_skew (
    .clk(clk), .rst_n(rst_n), .in_valid(issue_valid), .in_pass2(fb_pop),
    .in_row(sel_row), .col_data(col_data), .col_valid(col_valid),
    .col_pass2(col_pass2));

  assign ld_ready = !fr_full;
  assign fb_ready = !fb_full;
  assign full     = fr_full;
  assign empty    = !fr_has && !fb_has;

  // R5: a waiting feedback row takes the slot whenever issue is allowed.
  assert_feedback_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_has && issue_en) |-> (fb_pop && !fr_pop));

  // R5: the wavefront marks exactly the feedback rows as second pass.
  assert_pass2_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pop |=> (col_valid[0] && col_pass2[0]));

  // R7: with issue held off nothing new enters column 0.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_en |=> !col_valid[0]);

  // R9: nothing stored means an idle slot next.
  assert_empty_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> !col_valid[0]);

endmodule

// File: tb/line_skew_feeder_test.sv
module line_skew_feeder_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int LANES = 4;

  logic clk = 0;
  logic rst_n, issue_en, ld_valid, fb_valid;
  logic [LANES*W-1:0] ld_row, fb_row, col_data;
  logic ld_ready, fb_ready, empty, full;
  logic [LANES-1:0] col_valid, col_pass2;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_skew_feeder #(.W(W), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .issue_en(issue_en),
    .ld_valid(ld_valid), .ld_row(ld_row), .ld_ready(ld_ready),
    .fb_valid(fb_valid), .fb_row(fb_row), .fb_ready(fb_ready),
    .col_data(col_data), .col_valid(col_valid), .col_pass2(col_pass2),
    .empty(empty), .full(full));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Row built from a base tag: lane k holds base*16 + k.
  function automatic logic [LANES*W-1:0] mk_row(input int base);
    logic [LANES*W-1:0] r;
    for (int k = 0; k < LANES; k++) r[k*W +: W] = W'(base * 16 + k);
    return r;
  endfunction

  function automatic logic [31:0] lane(input int k);
    return 32'(col_data[k*W +: W]);
  endfunction

  task automatic drain();
    ld_valid = 0; fb_valid = 0; issue_en = 1;
    repeat (12) step();
  endtask

  task automatic t_reset();
    rst_n = 0; issue_en = 0; ld_valid = 0; fb_valid = 0;
    ld_row = '0; fb_row = '0;
    repeat (3) step();
    chk("R1", "col_valid in reset", 32'(col_valid), 0);
    chk("R1", "col_data in reset", col_data[31:0] | col_data[63:32], 0);
    rst_n = 1;
    step();
    chk("R1", "col_valid after reset", 32'(col_valid), 0);
    chk("R1", "col_pass2 after reset", 32'(col_pass2), 0);
    chk("R1", "flags {empty,full,ld_ready,fb_ready}",
        {28'd0, empty, full, ld_ready, fb_ready}, 32'b1011);
  endtask

  task automatic t_single();
    logic [LANES*W-1:0] a;
    a = mk_row(3);
    issue_en = 1;
    ld_valid = 1; ld_row = a;
    step();
    ld_valid = 0;
    chk("R9", "empty with one row stored", 32'(empty), 0);
    chk("R2", "nothing issued on write edge", 32'(col_valid), 0);
    for (int c = 0; c < LANES; c++) begin
      step();
      chk("R3", $sformatf("col_valid diagonal step %0d", c), 32'(col_valid), 32'(1 << c));
      chk("R2", $sformatf("col%0d data", c), lane(c), 32'(a[c*W +: W]));
      for (int k = 0; k < LANES; k++)
        if (k != c) chk("R4", $sformatf("idle col%0d zero at step %0d", k, c), lane(k), 0);
      if (c == 0) chk("R9", "empty after issue", 32'(empty), 1);
    end
    step();
    chk("R4", "all idle after wavefront", 32'(col_valid), 0);
  endtask

  task automatic t_stream();
    issue_en = 1;
    for (int i = 0; i < 3; i++) begin
      ld_valid = 1; ld_row = mk_row(5 + i);
      step();
      chk("R8", "ld_ready while streaming", 32'(ld_ready), 1);
    end
    ld_valid = 0;
    step();
    chk("R8", "three diagonals in flight", 32'(col_valid), 32'b0111);
    chk("R8", "col0 holds third row", lane(0), 32'(7 * 16 + 0));
    chk("R8", "col1 holds second row", lane(1), 32'(6 * 16 + 1));
    chk("R8", "col2 holds first row", lane(2), 32'(5 * 16 + 2));
    drain();
  endtask

  task automatic t_priority();
    issue_en = 0;
    ld_valid = 1; ld_row = mk_row(9);
    fb_valid = 1; fb_row = mk_row(10);
    step();
    ld_valid = 0; fb_valid = 0;
    step();
    chk("R7", "no issue while held", 32'(col_valid), 0);
    chk("R9", "not empty while held", 32'(empty), 0);
    issue_en = 1;
    step();
    chk("R5", "feedback row first on col0", lane(0), 32'(10 * 16));
    chk("R5", "feedback marked pass2", 32'(col_pass2), 32'b0001);
    step();
    chk("R5", "fresh row second on col0", lane(0), 32'(9 * 16));
    chk("R5", "feedback lane1 on col1", lane(1), 32'(10 * 16 + 1));
    chk("R5", "pass2 mask {col1 only}", 32'(col_pass2), 32'b0010);
    drain();
  endtask

  task automatic t_capacity();
    issue_en = 0;
    for (int i = 0; i < 8; i++) begin
      chk("R6", $sformatf("ld_ready before row %0d", i), 32'(ld_ready), 1);
      ld_valid = 1; ld_row = mk_row(16 + i);
      step();
    end
    chk("R6", "full at eight rows", 32'(full), 1);
    chk("R6", "ld_ready low when full", 32'(ld_ready), 0);
    ld_row = mk_row(40);
    step();
    ld_valid = 0;
    issue_en = 1;
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R6", $sformatf("stored row %0d in order", i), lane(0), 32'((16 + i) * 16));
      if (i == 0) chk("R6", "full drops after issue", 32'(full), 0);
    end
    chk("R9", "empty after draining eight", 32'(empty), 1);
    step();
    chk("R6", "dropped row never issued", 32'(col_valid[0]), 0);
    drain();
    issue_en = 0;
    for (int i = 0; i < 4; i++) begin
      fb_valid = 1; fb_row = mk_row(48 + i);
      step();
    end
    chk("R6", "fb_ready low with four feedback rows", 32'(fb_ready), 0);
    fb_row = mk_row(60);
    step();
    fb_valid = 0;
    issue_en = 1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R6", $sformatf("feedback row %0d", i), lane(0), 32'((48 + i) * 16));
      chk("R5", "feedback tagged pass2", 32'(col_pass2[0]), 1);
    end
    step();
    chk("R6", "dropped feedback row never issued", 32'(col_valid[0]), 0);
    drain();
  endtask

  task automatic t_stall();
    issue_en = 1;
    ld_valid = 1; ld_row = mk_row(70);
    step();
    ld_row = mk_row(71);
    step();
    ld_valid = 0; issue_en = 0;
    step();
    chk("R7", "col0 starved while held", 32'(col_valid[0]), 0);
    chk("R7", "col0 zero while held", lane(0), 0);
    chk("R7", "in-flight row reaches col1", lane(1), 32'(70 * 16 + 1));
    issue_en = 1;
    step();
    chk("R7", "held row resumes on col0", lane(0), 32'(71 * 16));
    chk("R7", "in-flight row reaches col2", lane(2), 32'(70 * 16 + 2));
    chk("R7", "diagonal with gap", 32'(col_valid), 32'b0101);
    drain();
  endtask

  initial begin
    t_reset();
    t_single();
    t_stream();
    t_priority();
    t_capacity();
    t_stall();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule